// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects a vector of level-sensitive interrupt request lines and presents them to two parent interrupt inputs. Every source has one enable bit and one routing bit. A source reaches a parent output only when its line is high and its enable bit is set. The routing bit picks which of the two outputs it reaches. Each parent output is the OR of the status bits routed to it.

Software uses a 32-bit register port with an address, a write enable, write data and combinational read data. The enable vector is never written directly. One offset sets enable bits wherever the written word has a one. Another offset clears them wherever the word has a one. Because of this, separate drivers can mask and unmask their own sources without a read-modify-write race.

The routing vector is an ordinary read/write register. The raw line state can be read at one offset. Each parent output has its own masked status view. The status views are registered, so they trail the lines and the enable state by one clock. Sources are cleared at the peripheral that raised them. The router holds no latched pending state.

Top module: `irq_router_top`

## Requirements
- R1: After reset the enable vector and the routing vector are all zeros. Both status views read zero and both `irqOut` bits are low.
- R2: A write to offset 0x080 sets the enable bit of every source whose data bit is 1. Every other enable bit keeps its value.
- R3: A write to offset 0x078 clears the enable bit of every source whose data bit is 1. Every other enable bit keeps its value.
- R4: Offset 0x000 is the routing vector and can be read and written. Bit n = 0 sends source n to output 0. Bit n = 1 sends it to output 1. Only a write to this offset changes it.
- R5: A read of offset 0x0A4 returns the present level of every source line, without masking. Source n is on bit n.
- R6: Offset 0x09C returns the status for output 0, which is line AND enable AND NOT routing. This view is taken from the values at the previous clock edge.
- R7: Offset 0x0A0 returns the status for output 1, which is line AND enable AND routing. This view is also taken from the values at the previous clock edge.
- R8: `irqOut[k]` is high exactly when the status view for output k has any bit set.
- R9: Writing all ones to offset 0x078 masks every source. No status bit and no `irqOut` bit is set after that, whatever the lines do.
- R10: A read of offset 0x078 or offset 0x080 returns the current enable vector.
- R11: An offset that is not listed above reads as zero. A write to such an offset changes neither the enable vector nor the routing vector.
- R12: Status is level-driven. When a line drops, its status bit and any output it alone drove fall one clock later, and no clearing write is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe for the current offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| srcLines | input | 32 | Level interrupt request lines |
| irqOut | output | 2 | Parent interrupt outputs 0 and 1 |

## Verification
Some cases are hard to reach from the ports. One is a source whose routing bit changes while its line is high and it is enabled, so the request moves from one parent to the other without ever being masked. Another is set and clear writes that each touch only part of the enable vector. The bench reaches these with a pseudo-random sequence. At each step it sets some enable bits, clears others and rewrites the routing vector, all while the lines are held at a random pattern. It then walks a single active line across every bit position with alternating routing. This shows that each status bit lands on the correct parent and falls as soon as its line drops.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int OFS_ROUTE  = 'h000;
  localparam int OFS_MASKCL = 'h078;
  localparam int OFS_MASKST = 'h080;
  localparam int OFS_STAT0  = 'h09C;
  localparam int OFS_STAT1  = 'h0A0;
  localparam int OFS_LEVEL  = 'h0A4;

  localparam int NUM_PARENT = 2;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic wrRoute;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ROUTE,
    RD_ENABLE,
    RD_STAT0,
    RD_STAT1,
    RD_LEVEL
  } rdsel_e;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output strobe_t           strb,
  output rdsel_e            rdSel
);

  logic hitRoute, hitClr, hitSet, hitStat0, hitStat1, hitLevel;

  always_comb begin
    hitRoute = (addr == ADDR_W'(OFS_ROUTE));
    hitClr   = (addr == ADDR_W'(OFS_MASKCL));
    hitSet   = (addr == ADDR_W'(OFS_MASKST));
    hitStat0 = (addr == ADDR_W'(OFS_STAT0));
    hitStat1 = (addr == ADDR_W'(OFS_STAT1));
    hitLevel = (addr == ADDR_W'(OFS_LEVEL));
  end

  always_comb begin
    strb.setEn   = wrEn && hitSet;
    strb.clrEn   = wrEn && hitClr;
    strb.wrRoute = wrEn && hitRoute;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (hitRoute)               rdSel = RD_ROUTE;
    else if (hitClr || hitSet)  rdSel = RD_ENABLE;
    else if (hitStat0)          rdSel = RD_STAT0;
    else if (hitStat1)          rdSel = RD_STAT1;
    else if (hitLevel)          rdSel = RD_LEVEL;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setEn, strb.clrEn, strb.wrRoute})); // R11

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0)); // R11

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  rdsel_e             rdSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_PARENT-1:0] irqOut
);

  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] routeQ;
  logic [NUM_SRC-1:0] statQ [NUM_PARENT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (strb.setEn) begin
      enQ <= enQ | wrData;
    end else if (strb.clrEn) begin
      enQ <= enQ & ~wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeQ <= '0;
    end else if (strb.wrRoute) begin
      routeQ <= wrData;
    end
  end

  for (genvar k = 0; k < NUM_PARENT; k++) begin : g_parent
    logic [NUM_SRC-1:0] selMask;
    assign selMask = (k == 0) ? ~routeQ : routeQ;

    always_ff @(posedge clk) begin
      if (!rstN) statQ[k] <= '0;
      else       statQ[k] <= srcIn & enQ & selMask;
    end

    assign irqOut[k] = |statQ[k];
  end

  always_comb begin
    unique case (rdSel)
      RD_ROUTE:  rdData = routeQ;
      RD_ENABLE: rdData = enQ;
      RD_STAT0:  rdData = statQ[0];
      RD_STAT1:  rdData = statQ[1];
      RD_LEVEL:  rdData = srcIn;
      default:   rdData = '0;
    endcase
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> ((enQ & $past(wrData)) == $past(wrData))); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> ((enQ & $past(wrData)) == '0)); // R3

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setEn || strb.clrEn) |=> $stable(enQ)); // R11

  AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrRoute |=> $stable(routeQ)); // R4

  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statQ[0] | statQ[1]) & ~$past(enQ)) == '0)); // R9

  AST_PARENTS_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[0] & statQ[1]) == '0); // R6

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic [NUM_PARENT-1:0] irqOut
);

  strobe_t strb;
  rdsel_e  rdSel;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (regAddr),
    .wrEn  (regWrEn),
    .strb  (strb),
    .rdSel (rdSel)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (regWrData),
    .srcIn  (srcLines),
    .rdData (regRdData),
    .irqOut (irqOut)
  );

  AST_LINE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (srcLines == '0) |=> (irqOut == '0)); // R12

endmodule

// File: tb/sim_irq_router_top.sv
module sim_irq_router_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] srcLines = '0;
  logic [1:0]  irqOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] enM = '0;
  logic [31:0] routeM = '0;
  logic [31:0] seed = 32'h1F2E_3D4C;

  always #10 clk = ~clk;

  irq_router_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .srcLines(srcLines), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkStatus(input string tag);
    logic [31:0] v;
    logic [31:0] e0 = srcLines & enM & ~routeM;
    logic [31:0] e1 = srcLines & enM & routeM;
    rd(12'h09C, v); check({tag, " R6 stat0"}, v, e0);
    rd(12'h0A0, v); check({tag, " R7 stat1"}, v, e1);
    check({tag, " R8 irq"}, {30'd0, irqOut}, {30'd0, |e1, |e0});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(12'h080, v); check("R1 enable", v, 32'h0);
    rd(12'h000, v); check("R1 route", v, 32'h0);
    srcLines = 32'hFFFF_FFFF;
    settle();
    checkStatus("R1");

    // R4 routing vector read/write
    for (int i = 0; i < 4; i++) begin
      seed = nextRand(seed);
      wr(12'h000, seed); routeM = seed;
      rd(12'h000, v); check("R4 route rw", v, routeM);
    end

    // R5 raw level read
    for (int i = 0; i < 4; i++) begin
      seed = nextRand(seed);
      srcLines = seed;
      rd(12'h0A4, v); check("R5 raw", v, seed);
    end

    // R2 R3 R10 mixed partial set/clear with route changes
    for (int i = 0; i < 40; i++) begin
      seed = nextRand(seed); srcLines = seed;
      seed = nextRand(seed); wr(12'h080, seed); enM = enM | seed;
      rd(12'h080, v); check("R2 set read", v, enM);
      seed = nextRand(seed); wr(12'h078, seed & 32'h5A5A_5A5A); enM = enM & ~(seed & 32'h5A5A_5A5A);
      rd(12'h078, v); check("R3 R10 clear read", v, enM);
      seed = nextRand(seed); wr(12'h000, seed); routeM = seed;
      settle();
      checkStatus("mix");
    end

    // R12 walking single line with alternating routing
    wr(12'h080, 32'hFFFF_FFFF); enM = 32'hFFFF_FFFF;
    wr(12'h000, 32'hAAAA_AAAA); routeM = 32'hAAAA_AAAA;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk) srcLines = 32'h1 << i;
      settle();
      check("R8 walk irq", {30'd0, irqOut}, (i % 2 == 1) ? 32'h2 : 32'h1);
      @(negedge clk) srcLines = '0;
      settle();
      check("R12 drop", {30'd0, irqOut}, 32'h0);
    end

    // R9 disable all
    srcLines = 32'hFFFF_FFFF;
    wr(12'h078, 32'hFFFF_FFFF); enM = '0;
    settle();
    checkStatus("R9");
    check("R9 irq low", {30'd0, irqOut}, 32'h0);

    // R11 unmapped offsets
    wr(12'h080, 32'h0F0F_0000); enM = 32'h0F0F_0000;
    foreach (seed[i]) begin end
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h07C, 32'h0000_0000);
    wr(12'h0A8, 32'h1234_5678);
    rd(12'h004, v); check("R11 unmapped read", v, 32'h0);
    rd(12'h0FC, v); check("R11 unmapped read hi", v, 32'h0);
    rd(12'h080, v); check("R11 enable kept", v, enM);
    rd(12'h000, v); check("R11 route kept", v, routeM);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule